// File: doc/BRIEF.md
# Run-State Controller for a Pattern Generator and Recorder

This block sets the operating mode of a pattern generator and recorder. It has four modes: Halt, Ready, Pause and Run. It decides when the step sequencer may advance. It also decides when the program counters of the cycle, capture and generation engines are held at zero. Its inputs are software commands, an asynchronous active-low pause line, and single-cycle event pulses (trigger, start, stop) that are already qualified upstream. The step sequencer also sends end-of-cycle requests to halt or pause.

Every program begins and ends in Halt. To leave Halt, software arms the block and a trigger pulse then follows. A start pulse moves the block from Ready into a frozen Pause. A later trigger releases it into Run. Run returns to Pause on any pause source. It returns to Halt on a stop event or on an end-of-cycle halt request. A halt command from software forces Halt from any mode.

The pause line passes through two flops before use. Once the synchronized line is low, the run enable drops in that same cycle, and the mode becomes Pause at the next edge.

Top module: `run_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is Halt (encoding: Halt=0, Ready=1, Pause=2, Run=3), `pc_clear_o` is 1 and `seq_run_o` is 0.
- R2: From Halt, a trigger pulse moves to Ready only if `sw_arm_i` was seen in an earlier cycle while in Halt. A trigger without a prior arm is ignored. A halt command in Halt cancels a pending arm.
- R3: In Ready, a start pulse moves to Pause. Trigger, pause and stop inputs have no effect in Ready.
- R4: In Pause, a trigger pulse moves to Run. `seq_run_o` is 1 only in Run.
- R5: In Run, a software pause command or a sequencer end-of-cycle pause request moves to Pause at the next edge.
- R6: The active-low pause line reaches the logic after two flop stages. In the first cycle that the synchronized line is low while in Run, `seq_run_o` is 0. The mode becomes Pause at the next edge.
- R7: In Run, a stop pulse or a sequencer end-of-cycle halt request moves to Halt.
- R8: In Halt, the pause, start and stop inputs have no effect. `pc_clear_o` is 1 exactly when the mode is Halt.
- R9: A software halt command moves to Halt at the next edge from any mode, whatever else is asserted.
- R10: When inputs coincide, priority from highest to lowest is: halt command, then stop or end-of-cycle halt, then the external pause line, then the other pause sources, then trigger or start. While the synchronized pause line is low, a trigger in Pause is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_arm_i | input | 1 | Software arm command (one cycle) |
| sw_halt_i | input | 1 | Software reset/halt command |
| sw_pause_i | input | 1 | Software pause command |
| ext_pause_n_i | input | 1 | Asynchronous external pause line, active low |
| trig_i | input | 1 | Qualified trigger pulse |
| start_i | input | 1 | Qualified start pulse |
| stop_i | input | 1 | Qualified stop pulse |
| eoc_halt_i | input | 1 | Sequencer end-of-cycle halt request |
| eoc_pause_i | input | 1 | Sequencer end-of-cycle pause request |
| mode_o | output | 2 | Current mode: 0 Halt, 1 Ready, 2 Pause, 3 Run |
| seq_run_o | output | 1 | Step sequencer advance enable |
| pc_clear_o | output | 1 | Synchronous clear for the program counters |

## Verification
The hardest case to reach is the external pause line meeting another condition in the one cycle where its synchronized copy first goes low. The line is two flop stages away from the state logic, so a stop pulse or a trigger must be timed to land exactly two edges after the line falls. The bench drives the line low, counts two edges, and only then raises the competing stop or trigger. Before the mode change it checks that the enable has dropped while the mode still reads Run.

// File: rtl/run_mode_ctrl.sv
module run_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_arm_i,
  input  logic       sw_halt_i,
  input  logic       sw_pause_i,
  input  logic       ext_pause_n_i,
  input  logic       trig_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       eoc_halt_i,
  input  logic       eoc_pause_i,
  output logic [1:0] mode_o,
  output logic       seq_run_o,
  output logic       pc_clear_o
);

  localparam logic [1:0] M_HALT  = 2'd0;
  localparam logic [1:0] M_READY = 2'd1;
  localparam logic [1:0] M_PAUSE = 2'd2;
  localparam logic [1:0] M_RUN   = 2'd3;

  logic [1:0] mode_q, mode_d;
  logic       armed_q, armed_d;
  logic       xp_meta_q, xp_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp_meta_q <= 1'b1;
      xp_sync_q <= 1'b1;
    end else begin
      xp_meta_q <= ext_pause_n_i;
      xp_sync_q <= xp_meta_q;
    end
  end

  wire xp_low   = !xp_sync_q;
  wire stop_req = stop_i || eoc_halt_i;
  wire int_pause = sw_pause_i || eoc_pause_i;

  always_comb begin
    mode_d  = mode_q;
    armed_d = 1'b0;
    if (sw_halt_i) begin
      mode_d = M_HALT;
    end else begin
      unique case (mode_q)
        M_HALT: begin
          if (armed_q && trig_i) mode_d = M_READY;
          else armed_d = armed_q || sw_arm_i;
        end
        M_READY: if (start_i) mode_d = M_PAUSE;
        M_PAUSE: if (!xp_low && trig_i) mode_d = M_RUN;
        M_RUN: begin
          if (stop_req)       mode_d = M_HALT;
          else if (xp_low)    mode_d = M_PAUSE;
          else if (int_pause) mode_d = M_PAUSE;
        end
        default: mode_d = M_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_HALT;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign mode_o     = mode_q;
  assign seq_run_o  = (mode_q == M_RUN) && !xp_low;
  assign pc_clear_o = (mode_q == M_HALT);

  AST_HALT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_halt_i |=> mode_q == M_HALT); // R9

  AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_READY && $past(mode_q) == M_HALT) |-> $past(trig_i)); // R2

  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && $past(mode_q) != M_RUN) |-> ($past(mode_q) == M_PAUSE && $past(trig_i))); // R4

  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PAUSE && $past(mode_q) != M_PAUSE) |-> ($past(mode_q) == M_RUN || $past(mode_q) == M_READY)); // R5

  AST_EXT_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && xp_low && !sw_halt_i && !stop_req) |=> mode_q == M_PAUSE); // R6

  AST_STOP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && stop_req) |=> mode_q == M_HALT); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALT && !trig_i) |=> mode_q == M_HALT); // R8

  AST_NO_RUN_PAUSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PAUSE && xp_low && !sw_halt_i) |=> mode_q == M_PAUSE); // R10

endmodule

// File: tb/run_mode_ctrl_bench.sv
module run_mode_ctrl_bench;
  localparam int PERIOD = 10;

  localparam logic [1:0] HLT = 2'd0, RDY = 2'd1, PAU = 2'd2, RUN = 2'd3;
  localparam logic [7:0] A  = 8'h80, H = 8'h40, P = 8'h20, T = 8'h10;
  localparam logic [7:0] S  = 8'h08, X = 8'h04, EH = 8'h02, EP = 8'h01;
  localparam int NV = 40;
  // {requirement number, inputs {arm,halt,pause,trig,start,stop,eoc_halt,eoc_pause}, expected mode}
  localparam logic [13:0] VEC [NV] = '{
    {4'd2,  T, HLT},               // R2 trigger without arm
    {4'd8,  P|S|X|EH|EP, HLT},     // R8 ignored in Halt
    {4'd2,  A, HLT},
    {4'd9,  H, HLT},               // R9 halt cancels arm
    {4'd2,  T, HLT},               // R2
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},               // R2
    {4'd3,  T|P|X, RDY},           // R3 ignored in Ready
    {4'd10, H|S, HLT},             // R10 halt beats start
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU},               // R3
    {4'd4,  T, RUN},               // R4
    {4'd5,  P, PAU},               // R5
    {4'd4,  T, RUN},
    {4'd5,  EP, PAU},              // R5
    {4'd4,  T, RUN},
    {4'd10, P|X, HLT},             // R10 stop beats pause
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU},
    {4'd4,  T, RUN},
    {4'd7,  EH, HLT},              // R7
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU},
    {4'd4,  T, RUN},
    {4'd9,  H|P|T, HLT},           // R9 from Run
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU},
    {4'd4,  T, RUN},
    {4'd10, EH|EP, HLT},           // R10
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU},
    {4'd9,  H|T, HLT},             // R9 from Pause
    {4'd2,  A, HLT},
    {4'd2,  T, RDY},
    {4'd3,  S, PAU}
  };

  logic clk = 0, rst_n = 0;
  logic arm = 0, halt = 0, pse = 0, xp_n = 1, trig = 0, start = 0, stop = 0, eh = 0, ep = 0;
  logic [1:0] mode;
  logic run_en, pc_clr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  run_mode_ctrl u_run_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_arm_i(arm), .sw_halt_i(halt), .sw_pause_i(pse),
    .ext_pause_n_i(xp_n), .trig_i(trig), .start_i(start), .stop_i(stop),
    .eoc_halt_i(eh), .eoc_pause_i(ep), .mode_o(mode), .seq_run_o(run_en), .pc_clear_o(pc_clr)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {arm, halt, pse, trig, start, stop, eh, ep} = v;
    @(posedge clk);
    @(negedge clk);
    {arm, halt, pse, trig, start, stop, eh, ep} = '0;
  endtask

  task automatic chk_mode(input logic [1:0] exp, input string tag);
    chk(mode, exp, {tag, " mode"});
    chk(run_en, exp == RUN, {"R4 run enable (", tag, ")"});
    chk(pc_clr, exp == HLT, {"R8 counter clear (", tag, ")"});
  endtask

  task automatic idle; @(posedge clk); @(negedge clk); endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_mode(HLT, "R1 reset");
    rst_n = 1;
    idle();
    chk_mode(HLT, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:2]);
      chk_mode(VEC[i][1:0], $sformatf("R%0d vector %0d", VEC[i][13:10], i));
    end
    drive(T);
    chk_mode(RUN, "R4 into Run");

    // R6: synchronized low line drops enable before the mode moves
    xp_n = 0;
    idle();
    chk(run_en, 1, "R6 one edge after line low");
    idle();
    chk(mode, RUN, "R6 mode still Run");
    chk(run_en, 0, "R6 enable dropped immediately");
    idle();
    chk(mode, PAU, "R6 paused");
    // R10: trigger blocked while line low
    drive(T);
    chk(mode, PAU, "R10 trigger blocked by pause line");
    xp_n = 1;
    idle(); idle();
    drive(T);
    chk_mode(RUN, "R4 resume after line high");

    // R10: stop beats external pause in the same cycle
    xp_n = 0;
    idle(); idle();
    drive(X);
    chk_mode(HLT, "R10 stop over external pause");

    // R8: external pause ignored in Halt
    idle(); idle();
    chk_mode(HLT, "R8 line low in Halt");
    drive(A);
    drive(T);
    chk(mode, RDY, "R8 Halt exit unaffected by line");
    drive(S);
    chk(mode, PAU, "R3 start with line low");
    xp_n = 1;
    idle(); idle();
    drive(T);
    chk(mode, RUN, "R4 run again");
    // R9: halt beats external pause
    xp_n = 0;
    idle(); idle();
    drive(H);
    chk_mode(HLT, "R9 halt over external pause");
    xp_n = 1;

    // R1: asynchronous reset from Ready
    idle(); idle();
    drive(A); drive(T);
    chk(mode, RDY, "R2 ready before reset");
    rst_n = 0;
    #1;
    chk_mode(HLT, "R1 async reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule